// File: doc/BRIEF.md
# Oversampled Manchester Clock and Data Recovery

This block takes an asynchronous Manchester-coded serial line and recovers both the bit timing and the bit values, using only a local system clock that runs at about eight times the expected bit rate. It is built from plain synchronous logic: a synchronizer, a transition detector, a quiet-gap timer and a decision state machine. There is no analog loop and no delay element.

Each recovered bit leaves the block as a level on `bit_o` together with a strobe on `valid_o` that lasts one system clock. `lock_o` reports that the block is following a live stream. Every bit carries a transition at its centre. A second transition may fall on the boundary between two equal bits, and the block has to tell the two kinds apart. It does so by timing each transition against the last accepted centre transition. The gate is set to three quarters of the most recently measured bit period, so a single build stays correct from 5 to 12 clocks per bit.

The stream may be of any length. It must open with two bits of opposite value, so that the first two transitions the block sees are both bit centres. Framing and word assembly belong to the logic downstream.

Top module: `manchester_cdr`

## Requirements
- R1: While `rst_ni` is low, `bit_o`, `valid_o` and `lock_o` are all 0.
- R2: `line_i` passes through two synchronizing flops. When `line_i` changes between two rising edges and that change is accepted as a bit centre, `valid_o` is high after the third rising edge that follows the change.
- R3: While unlocked, the first transition is accepted as a bit centre. It produces a bit, and `lock_o` rises in the same cycle as that bit's `valid_o`.
- R4: The bit value is the line level just after the accepted centre transition: a falling transition (high to low) gives 0 and a rising transition gives 1. With parameter `INVERT` = 1 every recovered bit is complemented and the strobe timing is unchanged.
- R5: `valid_o` is high for exactly one system clock per recovered bit, and never in two consecutive cycles.
- R6: During acquisition, after the first accepted transition, a transition that arrives fewer than `MIN_RATIO` (5) clocks after it is ignored. The next transition at `MIN_RATIO` clocks or later is accepted, and its spacing becomes the learned bit period.
- R7: Once locked, a transition is accepted as a bit centre only if it arrives at least ceil(3·P/4) clocks after the previous accepted centre. P is the last centre-to-centre spacing, clamped to 5..12. Earlier transitions produce no bit.
- R8: For any whole ratio from 5 to 12 clocks per bit, and for streams of any length that begin with two opposite bits, the recovered bits equal the transmitted bits in order, with no bits added or lost.
- R9: When more than `TIMEOUT` (16) clocks pass with no line transition, `lock_o` falls. With the last transition applied at the falling clock edge N, `lock_o` is still high at edge N+19 and low at edge N+20. The next transition restarts acquisition.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, about 8x the bit rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_i | input | 1 | Asynchronous Manchester line |
| bit_o | output | 1 | Last recovered bit value |
| valid_o | output | 1 | One-cycle strobe per recovered bit |
| lock_o | output | 1 | High while a stream is being followed |

## Verification
The hardest cases are the ones that sit exactly on a timing edge. The first is a transition that lands precisely on the three-quarter gate, or one clock short of it. The second is a quiet gap of exactly 16 clocks against 17. Random Manchester traffic at whole ratios almost never produces these spacings. A directed sequence therefore toggles the line at chosen falling clock edges, counted from a known first transition. That sequence places an ignored transition one clock before the gate and an accepted one exactly on it. It then relearns a shorter period, which moves the gate, and stops the line at a counted distance so the lock drop can be checked clock by clock.

// File: rtl/mcdr_pkg.sv
package mcdr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACQ  = 2'd1,
    ST_LOCK = 2'd2
  } mcdr_state_e;
endpackage

// File: rtl/mcdr_sync.sv
module mcdr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/mcdr_edge.sv
module mcdr_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic level_i,
  output logic edge_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= level_i;
  end

  assign edge_o = level_i ^ prev_q;
endmodule

// File: rtl/mcdr_gap.sv
module mcdr_gap #(
  parameter int TIMEOUT = 16,
  parameter int CW      = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          edge_i,
  output logic          timeout_o,
  output logic [CW-1:0] quiet_o
);
  localparam logic [CW-1:0] LimC = CW'(TIMEOUT);
  localparam logic [CW-1:0] SatC = '1;

  logic [CW-1:0] quiet_q;

  // clocks elapsed since the last transition, saturating
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              quiet_q <= '0;
    else if (edge_i)          quiet_q <= CW'(1);
    else if (quiet_q != SatC) quiet_q <= quiet_q + CW'(1);
  end

  assign timeout_o = !edge_i && (quiet_q > LimC);
  assign quiet_o   = quiet_q;
endmodule

// File: rtl/mcdr_decide.sv
module mcdr_decide
  import mcdr_pkg::*;
#(
  parameter int MIN_P  = 5,
  parameter int MAX_P  = 12,
  parameter int NOM_P  = 8,
  parameter int CW     = 5,
  parameter bit INVERT = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic edge_i,
  input  logic level_i,
  input  logic timeout_i,
  output logic bit_o,
  output logic valid_o,
  output logic lock_o
);
  localparam logic [CW-1:0] MinC = CW'(MIN_P);
  localparam logic [CW-1:0] MaxC = CW'(MAX_P);
  localparam logic [CW-1:0] NomC = CW'(NOM_P);
  localparam logic [CW-1:0] SatC = '1;

  mcdr_state_e   state_q, state_d;
  logic [CW-1:0] mid_q, period_q, gate, spacing;
  logic          accept, bit_q, valid_q;

  // ceil(3/4 of learned period)
  assign gate = CW'((32'(period_q) * 3 + 3) >> 2);

  always_comb begin
    if (mid_q > MaxC)      spacing = MaxC;
    else if (mid_q < MinC) spacing = MinC;
    else                   spacing = mid_q;
  end

  always_comb begin
    accept  = 1'b0;
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        accept = edge_i;
        if (edge_i) state_d = ST_ACQ;
      end
      ST_ACQ: begin
        if (timeout_i) state_d = ST_IDLE;
        else if (edge_i && mid_q >= MinC) begin
          accept  = 1'b1;
          state_d = ST_LOCK;
        end
      end
      ST_LOCK: begin
        if (timeout_i) state_d = ST_IDLE;
        else accept = edge_i && (mid_q >= gate);
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      mid_q    <= '0;
      period_q <= NomC;
      bit_q    <= 1'b0;
      valid_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      valid_q <= accept;
      if (accept)              mid_q <= CW'(1);
      else if (mid_q != SatC)  mid_q <= mid_q + CW'(1);
      if (accept && state_q != ST_IDLE) period_q <= spacing;
      if (accept)              bit_q <= level_i ^ INVERT;
    end
  end

  assign bit_o   = bit_q;
  assign valid_o = valid_q;
  assign lock_o  = (state_q != ST_IDLE);

  // R5
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |=> !valid_q);

  // R7
  period_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_LOCK) |-> (period_q >= MinC && period_q <= MaxC));
endmodule

// File: rtl/manchester_cdr.sv
module manchester_cdr #(
  parameter int NOM_RATIO   = 8,
  parameter int MIN_RATIO   = 5,
  parameter int MAX_RATIO   = 12,
  parameter int TIMEOUT     = 16,
  parameter int SYNC_STAGES = 2,
  parameter bit INVERT      = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic bit_o,
  output logic valid_o,
  output logic lock_o
);
  localparam int CW = $clog2(((TIMEOUT > MAX_RATIO) ? TIMEOUT : MAX_RATIO) + 2);
  localparam logic [CW-1:0] LimC = CW'(TIMEOUT);

  logic          level_w, edge_w, timeout_w;
  logic [CW-1:0] quiet_w;

  mcdr_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(line_i), .q_o(level_w)
  );

  mcdr_edge i_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .level_i(level_w), .edge_o(edge_w)
  );

  mcdr_gap #(.TIMEOUT(TIMEOUT), .CW(CW)) i_gap (
    .clk_i(clk_i), .rst_ni(rst_ni), .edge_i(edge_w),
    .timeout_o(timeout_w), .quiet_o(quiet_w)
  );

  mcdr_decide #(
    .MIN_P(MIN_RATIO), .MAX_P(MAX_RATIO), .NOM_P(NOM_RATIO),
    .CW(CW), .INVERT(INVERT)
  ) i_decide (
    .clk_i(clk_i), .rst_ni(rst_ni), .edge_i(edge_w), .level_i(level_w),
    .timeout_i(timeout_w), .bit_o(bit_o), .valid_o(valid_o), .lock_o(lock_o)
  );

  // R3
  strobe_locked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> lock_o);

  // R3
  lock_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_o) |-> valid_o);

  // R9
  lock_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(lock_o) |-> ($past(quiet_w) > LimC));
endmodule

// File: tb/test_manchester_cdr.sv
module test_manchester_cdr;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line = 1'b0;
  logic bit_w, valid_w, lock_w;
  logic bit_x, valid_x, lock_x;

  int total = 0;
  int fails = 0;
  int rx_n = 0;
  int dbl = 0;
  int vmis = 0;
  logic rx [2048];
  logic rxi [2048];
  logic exp_b [1024];
  logic prev_v = 1'b0;

  // ratio[31:28] bits[27:16] seed[15:0]; every stream must decode exactly and end unlocked
  localparam int NV = 9;
  localparam logic [31:0] VEC [NV] = '{
    32'h5028ACE1, 32'h602813F7, 32'h70285A5A, 32'h8028C3D2, 32'h90287E11,
    32'hA0282468, 32'hB028F00D, 32'hC0289A3B, 32'h8258BEEF
  };

  always #10 clk = ~clk;

  manchester_cdr i_manchester_cdr (
    .clk_i(clk), .rst_ni(rst_n), .line_i(line),
    .bit_o(bit_w), .valid_o(valid_w), .lock_o(lock_w)
  );

  manchester_cdr #(.INVERT(1'b1)) i_manchester_cdr_inv (
    .clk_i(clk), .rst_ni(rst_n), .line_i(line),
    .bit_o(bit_x), .valid_o(valid_x), .lock_o(lock_x)
  );

  always @(negedge clk) begin
    if (valid_w && rx_n < 2048) begin
      rx[rx_n]  = bit_w;
      rxi[rx_n] = bit_x;
      rx_n      = rx_n + 1;
    end
    if (valid_w && prev_v) dbl = dbl + 1;
    if (valid_w !== valid_x) vmis = vmis + 1;
    prev_v = valid_w;
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(bit ok, string req, int act, int expv);
    total = total + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  task automatic run_stream(int r, int n, logic [15:0] seed);
    int base, bad, badi;
    logic [15:0] lf;
    base = rx_n;
    lf = seed;
    exp_b[0] = !line;
    exp_b[1] = line;
    for (int i = 2; i < n; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      exp_b[i] = lf[0];
    end
    for (int i = 0; i < n; i++) begin
      line = !exp_b[i];
      tick(r / 2);
      line = exp_b[i];
      tick(r - r / 2);
    end
    tick(6);
    chk(rx_n - base == n, "R8 bit count", rx_n - base, n);
    bad = 0;
    badi = 0;
    for (int i = 0; i < n; i++) begin
      if (base + i < 2048) begin
        if (rx[base + i] !== exp_b[i]) bad++;
        if (rxi[base + i] !== !exp_b[i]) badi++;
      end
    end
    chk(bad == 0, "R8 bit values", bad, 0);
    chk(badi == 0, "R4 inverted values", badi, 0);
    tick(30);
    chk(lock_w == 1'b0, "R9 unlock after stream", int'(lock_w), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total = total + 1;
    fails = fails + 1;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
  end

  initial begin
    int base;
    // R1 reset state
    tick(3);
    chk(bit_w == 1'b0, "R1 bit", int'(bit_w), 0);
    chk(valid_w == 1'b0, "R1 valid", int'(valid_w), 0);
    chk(lock_w == 1'b0, "R1 lock", int'(lock_w), 0);
    rst_n = 1'b1;
    tick(20);
    chk(lock_w == 1'b0, "R1 idle lock", int'(lock_w), 0);

    // R2/R3 latency and acquisition, directed toggles at counted negedges
    base = rx_n;
    line = 1'b1;                                            // N0, accepted
    tick(1); chk(valid_w == 1'b0, "R2 latency n1", int'(valid_w), 0);
    tick(1); chk(valid_w == 1'b0, "R2 latency n2", int'(valid_w), 0);
    tick(1);
    chk(valid_w == 1'b1, "R2 latency n3", int'(valid_w), 1);
    chk(bit_w == 1'b1, "R4 rising gives 1", int'(bit_w), 1);
    chk(lock_w == 1'b1, "R3 lock with first bit", int'(lock_w), 1);
    line = 1'b0;                                            // N3, spacing 3 < MIN, ignored
    tick(4); chk(rx_n - base == 1, "R6 early edge ignored", rx_n - base, 1);
    tick(1); line = 1'b1;                                   // N8, spacing 8, period 8
    tick(8); line = 1'b0;                                   // N16, spacing 8, bit 0
    tick(4); chk(rx_n - base == 3, "R7 centres accepted", rx_n - base, 3);
    tick(1); line = 1'b1;                                   // N21, spacing 5 < gate 6
    tick(1); line = 1'b0;                                   // N22, spacing 6 == gate
    tick(4); chk(rx_n - base == 4, "R7 gate boundary", rx_n - base, 4);
    line = 1'b1;                                            // N26, spacing 4 < gate 5
    tick(1); line = 1'b0;                                   // N27, spacing 5 == gate 5
    tick(5); chk(rx_n - base == 5, "R7 relearned gate", rx_n - base, 5);
    chk({rx[base], rx[base+1], rx[base+2], rx[base+3], rx[base+4]} == 5'b11000,
        "R4 directed values",
        int'({rx[base], rx[base+1], rx[base+2], rx[base+3], rx[base+4]}), 24);
    chk({rxi[base], rxi[base+1], rxi[base+2], rxi[base+3], rxi[base+4]} == 5'b00111,
        "R4 inverted directed",
        int'({rxi[base], rxi[base+1], rxi[base+2], rxi[base+3], rxi[base+4]}), 7);
    // R9 exact drop: last toggle at N27
    tick(14); chk(lock_w == 1'b1, "R9 lock held at 19", int'(lock_w), 1);
    tick(1);  chk(lock_w == 1'b0, "R9 lock drop at 20", int'(lock_w), 0);
    tick(10);

    // R8 table of streams across the ratio band
    for (int k = 0; k < NV; k++)
      run_stream(int'(VEC[k][31:28]), int'(VEC[k][27:16]), VEC[k][15:0]);

    chk(dbl == 0, "R5 strobe width", dbl, 0);
    chk(vmis == 0, "R4 strobe timing with INVERT", vmis, 0);
    summary();
  end
endmodule